// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is a hardware state machine that takes a system from full-speed operation down to a halted, clock-gated state and back again. While it does so it keeps DRAM contents safe by moving the memory into self-refresh. It knows three clocking modes. In run, clocks come from the PLL. In direct-run, clocks come from the oscillator-derived system clock. In halt, the system clock is gated off. A transition between halt and run always passes through direct-run.

A suspend request starts the descent. The sequencer first waits for a quiet window on the memory controller: busy must be seen high and then low. It then asks for self-refresh and waits for the controller to confirm it. After that it drops to direct-run, gates the DRAM clock, powers the PLL down and asserts halt. A wake event brings the system back to direct-run with the PLL powered. Once the PLL reports lock, the exit ordering restores run mode, the DRAM clock and self-refresh release, and a one-cycle completion pulse follows. The PLL, the DRAM controller and the clock dividers are seen only through level handshake pins.

Every handshake wait is bounded by a programmable cycle limit. If a handshake never arrives, the sequencer abandons the sequence, returns to run and raises a sticky error flag.

Top module: `lpm_seq`

## Requirements
- R1: While reset is held and just after its release, outputs show run mode: run_sel=1, sr_req=0, sr_upd=0, dram_clk_en=1, pll_pwr=1, halt=0, done=0, err=0.
- R2: suspend_req is sampled only in the idle run state. Asserting it at any point of a sequence in progress, including the completion cycle, does not restart or alter that sequence.
- R3: After a suspend is accepted, sr_req stays low until mc_busy has been seen high and then low. The first cycle that mc_busy is seen low after being high is followed by sr_req rising on the next cycle.
- R4: Self-refresh is requested by raising sr_req for one cycle and then, with sr_req still high, sr_upd for exactly one cycle. sr_req then holds while the block waits for sr_ack=1, and run_sel stays high until sr_ack has been seen.
- R5: Entering halt follows this order, one step per cycle: run_sel falls; then dram_clk_en falls; then pll_pwr falls; then halt rises.
- R6: halt stays high until wake_evt is seen. The next cycle shows halt=0, pll_pwr=1 and run_sel=0 (direct-run). run_sel stays low until pll_lock has been seen.
- R7: Exit follows this order, one step per cycle: run_sel rises with sr_req low and dram_clk_en still low; then dram_clk_en rises; then sr_upd pulses for one cycle. The block then waits for sr_ack=0.
- R8: The cycle after sr_ack is seen low, done is high for exactly one cycle, and the block is idle in run again on the following cycle.
- R9: Each of the five waits (busy high, busy low, ack high, lock, ack low) advances if its handshake is seen in any of its first tmo_limit+1 cycles. Otherwise, on the cycle after that span, the block shows the run-mode pattern with err=1 and gives no done pulse.
- R10: err stays high until the next suspend is accepted, and it reads 0 from the cycle after that acceptance.
- R11: wake_evt has no effect in any state other than halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| suspend_req | input | 1 | Request to start a suspend sequence (sampled when idle) |
| wake_evt | input | 1 | Wake event, acted on only while halted |
| mc_busy | input | 1 | Memory controller busy flag |
| sr_ack | input | 1 | Memory controller reports self-refresh active |
| pll_lock | input | 1 | PLL lock indication |
| tmo_limit | input | TMO_W | Timeout limit for each handshake wait, in cycles minus one |
| run_sel | output | 1 | 1 selects PLL clocks (run), 0 selects system clock (direct-run) |
| sr_req | output | 1 | Self-refresh request level |
| sr_upd | output | 1 | One-cycle strobe that makes the controller take sr_req |
| dram_clk_en | output | 1 | DRAM clock enable |
| pll_pwr | output | 1 | PLL power-up control |
| halt | output | 1 | Stop control; gates the system clock |
| done | output | 1 | One-cycle pulse when self-refresh exit is confirmed |
| err | output | 1 | Sticky flag set by a handshake timeout |

## Verification
The hardest behaviour to reach from the ports is a timeout in the last wait, the one for self-refresh to clear. Getting there needs a full descent, a halt, a wake and a PLL relock first, and each earlier wait must succeed at exactly the right cycle. The stimulus drives every handshake from a script that holds it absent for a chosen number of cycles and then asserts it. The bench sweeps each of the five waits, one at a time, across delays from zero to one past the limit, for several limits. This reaches both the last cycle that still succeeds and the first cycle that times out in every wait, including the deep ones.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [3:0] {
    S_RUN    = 4'd0,
    S_WBUSY  = 4'd1,
    S_WIDLE  = 4'd2,
    S_SRREQ  = 4'd3,
    S_SRUPD  = 4'd4,
    S_WACK   = 4'd5,
    S_DIRECT = 4'd6,
    S_GATE   = 4'd7,
    S_PLLOFF = 4'd8,
    S_HALT   = 4'd9,
    S_WLOCK  = 4'd10,
    S_XRUN   = 4'd11,
    S_XCLK   = 4'd12,
    S_XUPD   = 4'd13,
    S_WCLR   = 4'd14,
    S_DONE   = 4'd15
  } lpm_state_e;

  typedef struct packed {
    logic run_sel;
    logic sr_req;
    logic sr_upd;
    logic dram_clk_en;
    logic pll_pwr;
    logic halt;
    logic done;
  } lpm_out_t;

  // States that wait on a handshake and are bounded by the timer
  function automatic logic is_wait(input lpm_state_e s);
    return (s == S_WBUSY) || (s == S_WIDLE) || (s == S_WACK) ||
           (s == S_WLOCK) || (s == S_WCLR);
  endfunction

  // Fixed successor of every state along the suspend/resume path
  function automatic lpm_state_e succ(input lpm_state_e s);
    case (s)
      S_RUN:    return S_WBUSY;
      S_WBUSY:  return S_WIDLE;
      S_WIDLE:  return S_SRREQ;
      S_SRREQ:  return S_SRUPD;
      S_SRUPD:  return S_WACK;
      S_WACK:   return S_DIRECT;
      S_DIRECT: return S_GATE;
      S_GATE:   return S_PLLOFF;
      S_PLLOFF: return S_HALT;
      S_HALT:   return S_WLOCK;
      S_WLOCK:  return S_XRUN;
      S_XRUN:   return S_XCLK;
      S_XCLK:   return S_XUPD;
      S_XUPD:   return S_WCLR;
      S_WCLR:   return S_DONE;
      default:  return S_RUN;
    endcase
  endfunction

endpackage

// File: rtl/lpm_wait_timer.sv
module lpm_wait_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          restart,
  input  logic [TW-1:0] limit,
  output logic          expired
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!arm || restart) begin
      cnt <= '0;
    end else if (cnt != limit) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = arm && (cnt == limit);

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> (cnt <= limit));

endmodule

// File: rtl/lpm_out_decode.sv
module lpm_out_decode
  import lpm_pkg::*;
(
  input  lpm_state_e state,
  output lpm_out_t   o
);

  always_comb begin
    o = '{run_sel: 1'b1, sr_req: 1'b0, sr_upd: 1'b0, dram_clk_en: 1'b1,
          pll_pwr: 1'b1, halt: 1'b0, done: 1'b0};
    case (state)
      S_SRREQ, S_WACK: o.sr_req = 1'b1;
      S_SRUPD: begin
        o.sr_req = 1'b1;
        o.sr_upd = 1'b1;
      end
      S_DIRECT: begin
        o.run_sel = 1'b0;
        o.sr_req  = 1'b1;
      end
      S_GATE, S_WLOCK: begin
        o.run_sel     = 1'b0;
        o.sr_req      = 1'b1;
        o.dram_clk_en = 1'b0;
      end
      S_PLLOFF: begin
        o.run_sel     = 1'b0;
        o.sr_req      = 1'b1;
        o.dram_clk_en = 1'b0;
        o.pll_pwr     = 1'b0;
      end
      S_HALT: begin
        o.run_sel     = 1'b0;
        o.sr_req      = 1'b1;
        o.dram_clk_en = 1'b0;
        o.pll_pwr     = 1'b0;
        o.halt        = 1'b1;
      end
      S_XRUN:  o.dram_clk_en = 1'b0;
      S_XUPD:  o.sr_upd = 1'b1;
      S_DONE:  o.done = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/lpm_ctrl_fsm.sv
module lpm_ctrl_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       suspend_req,
  input  logic       wake_evt,
  input  logic       mc_busy,
  input  logic       sr_ack,
  input  logic       pll_lock,
  input  logic       expired,
  output lpm_state_e state_q,
  output logic       arm,
  output logic       restart,
  output logic       err
);

  lpm_state_e state_d;
  logic       hs_met;

  // Handshake that ends the current wait
  always_comb begin
    case (state_q)
      S_WBUSY: hs_met = mc_busy;
      S_WIDLE: hs_met = !mc_busy;
      S_WACK:  hs_met = sr_ack;
      S_WLOCK: hs_met = pll_lock;
      S_WCLR:  hs_met = !sr_ack;
      default: hs_met = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    if (is_wait(state_q)) begin
      if (hs_met)       state_d = succ(state_q);
      else if (expired) state_d = S_RUN;
    end else begin
      case (state_q)
        S_RUN:   if (suspend_req) state_d = S_WBUSY;
        S_HALT:  if (wake_evt)    state_d = S_WLOCK;
        default: state_d = succ(state_q);
      endcase
    end
  end

  assign arm     = is_wait(state_q);
  assign restart = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_RUN;
      err     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_RUN && suspend_req)
        err <= 1'b0;
      else if (arm && !hs_met && expired)
        err <= 1'b1;
    end
  end

  // R3
  req_after_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_SRREQ) |-> !$past(mc_busy));

  // R4
  leave_run_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DIRECT) |-> $past(sr_ack));

  // R6
  run_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_XRUN) |-> $past(pll_lock));

  // R11
  wake_only_in_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WLOCK && $past(state_q) != S_WLOCK) |-> $past(state_q) == S_HALT);

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             suspend_req,
  input  logic             wake_evt,
  input  logic             mc_busy,
  input  logic             sr_ack,
  input  logic             pll_lock,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             run_sel,
  output logic             sr_req,
  output logic             sr_upd,
  output logic             dram_clk_en,
  output logic             pll_pwr,
  output logic             halt,
  output logic             done,
  output logic             err
);

  localparam int TW = (TMO_W < 1) ? 1 : TMO_W;

  lpm_state_e state;
  lpm_out_t   outs;
  logic       arm, restart, expired;

  lpm_ctrl_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .suspend_req(suspend_req), .wake_evt(wake_evt),
    .mc_busy(mc_busy), .sr_ack(sr_ack), .pll_lock(pll_lock), .expired(expired),
    .state_q(state), .arm(arm), .restart(restart), .err(err)
  );

  lpm_wait_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(arm), .restart(restart),
    .limit(tmo_limit), .expired(expired)
  );

  lpm_out_decode u_dec (.state(state), .o(outs));

  assign run_sel     = outs.run_sel;
  assign sr_req      = outs.sr_req;
  assign sr_upd      = outs.sr_upd;
  assign dram_clk_en = outs.dram_clk_en;
  assign pll_pwr     = outs.pll_pwr;
  assign halt        = outs.halt;
  assign done        = outs.done;

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_upd |=> !sr_upd);

  // R5
  halt_after_pll_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt) |-> ($past(!pll_pwr) && $past(!dram_clk_en) && $past(!run_sel)));

  // R6
  wake_to_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt) |-> (!run_sel && pll_pwr));

  // R9
  err_lands_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (run_sel && !sr_req && dram_clk_en && !done));

endmodule

// File: tb/lpm_seq_bench.sv
module lpm_seq_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       suspend_req, wake_evt, mc_busy, sr_ack, pll_lock;
  logic [7:0] tmo_limit;
  logic       run_sel, sr_req, sr_upd, dram_clk_en, pll_pwr, halt, done, err;

  int  nchk = 0;
  int  nerr = 0;
  int  lim  = 0;
  logic err_exp = 1'b0;

  // pattern order: run_sel sr_req sr_upd dram_clk_en pll_pwr halt done
  localparam logic [6:0] P_RUN    = 7'b1001100;
  localparam logic [6:0] P_SRREQ  = 7'b1101100;
  localparam logic [6:0] P_SRUPD  = 7'b1111100;
  localparam logic [6:0] P_DIRECT = 7'b0101100;
  localparam logic [6:0] P_GATE   = 7'b0100100;
  localparam logic [6:0] P_PLLOFF = 7'b0100000;
  localparam logic [6:0] P_HALT   = 7'b0100010;
  localparam logic [6:0] P_XRUN   = 7'b1000100;
  localparam logic [6:0] P_XUPD   = 7'b1011100;
  localparam logic [6:0] P_DONE   = 7'b1001101;

  always #5 clk = ~clk;

  lpm_seq u_lpm_seq (
    .clk(clk), .rst_n(rst_n), .suspend_req(suspend_req), .wake_evt(wake_evt),
    .mc_busy(mc_busy), .sr_ack(sr_ack), .pll_lock(pll_lock), .tmo_limit(tmo_limit),
    .run_sel(run_sel), .sr_req(sr_req), .sr_upd(sr_upd), .dram_clk_en(dram_clk_en),
    .pll_pwr(pll_pwr), .halt(halt), .done(done), .err(err)
  );

  wire [6:0] obs = {run_sel, sr_req, sr_upd, dram_clk_en, pll_pwr, halt, done};

  task automatic chk(input logic [6:0] exp, input string tag);
    nchk++;
    if (obs !== exp || err !== err_exp) begin
      nerr++;
      $display("FAIL %s: outs=%b err=%b expected outs=%b err=%b", tag, obs, err, exp, err_exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setsig(input int sig, input logic v);
    case (sig)
      0:       mc_busy  = v;
      1:       sr_ack   = v;
      default: pll_lock = v;
    endcase
  endtask

  // Handshake held absent for d cycles; expected to advance iff d <= lim
  task automatic do_wait(input int sig, input logic lvl, input int d,
                         input logic [6:0] pat, input string tag, output bit ok);
    for (int k = 0; ; k++) begin
      setsig(sig, (k >= d) ? lvl : ~lvl);
      chk(pat, tag);
      step();
      if (k >= d) begin ok = 1'b1; break; end
      if (k == lim) begin ok = 1'b0; break; end
    end
  endtask

  task automatic abort_seq();
    mc_busy = 1'b0; sr_ack = 1'b0; pll_lock = 1'b0; wake_evt = 1'b0;
    err_exp = 1'b1;
    chk(P_RUN, "R9 timeout returns to run with err");
  endtask

  task automatic run_seq(input int stg, input int d, input int hw);
    bit ok;
    chk(P_RUN, "R10 idle before accept");
    suspend_req = 1'b1;
    step();
    suspend_req = 1'b0;
    err_exp = 1'b0;
    do_wait(0, 1'b1, (stg == 0) ? d : 0, P_RUN, "R3 wait busy high", ok);
    if (!ok) begin abort_seq(); return; end
    do_wait(0, 1'b0, (stg == 1) ? d : 0, P_RUN, "R3 wait busy low", ok);
    if (!ok) begin abort_seq(); return; end
    chk(P_SRREQ, "R4 request raised");
    suspend_req = 1'b1;
    step();
    chk(P_SRUPD, "R4 update strobe R2");
    step();
    suspend_req = 1'b0;
    do_wait(1, 1'b1, (stg == 2) ? d : 0, P_SRREQ, "R4 wait ack", ok);
    if (!ok) begin abort_seq(); return; end
    chk(P_DIRECT, "R5 direct-run");
    wake_evt = 1'b1;
    step();
    chk(P_GATE, "R5 dram clock gated R11");
    step();
    wake_evt = 1'b0;
    chk(P_PLLOFF, "R5 pll off R11");
    step();
    for (int k = 0; k < hw; k++) begin
      chk(P_HALT, "R6 halt held");
      step();
    end
    wake_evt = 1'b1;
    chk(P_HALT, "R6 halt");
    step();
    wake_evt = 1'b0;
    do_wait(2, 1'b1, (stg == 3) ? d : 0, P_GATE, "R6 wait lock in direct-run", ok);
    if (!ok) begin abort_seq(); return; end
    chk(P_XRUN, "R7 run with request low");
    step();
    chk(P_RUN, "R7 dram clock back");
    step();
    chk(P_XUPD, "R7 update strobe");
    step();
    do_wait(1, 1'b0, (stg == 4) ? d : 0, P_RUN, "R7 wait ack clear", ok);
    if (!ok) begin abort_seq(); return; end
    chk(P_DONE, "R8 done pulse");
    suspend_req = 1'b1;
    step();
    suspend_req = 1'b0;
    chk(P_RUN, "R8 back to idle R2");
    pll_lock = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    suspend_req = 1'b0; wake_evt = 1'b0; mc_busy = 1'b0;
    sr_ack = 1'b0; pll_lock = 1'b0; tmo_limit = '0;
    repeat (3) @(negedge clk);
    chk(P_RUN, "R1 during reset");
    rst_n = 1'b1;
    step();
    chk(P_RUN, "R1 after reset");
    // R11: wake in idle must not start anything
    wake_evt = 1'b1;
    step();
    wake_evt = 1'b0;
    chk(P_RUN, "R11 wake ignored in run");

    for (int l = 0; l < 4; l++) begin
      lim = l;
      tmo_limit = 8'(l);
      for (int s = 0; s < 5; s++) begin
        for (int d = 0; d <= l + 1; d++) begin
          run_seq(s, d, d % 3);
        end
      end
    end

    lim = 200;
    tmo_limit = 8'd200;
    run_seq(3, 150, 4);
    run_seq(4, 200, 0);
    run_seq(0, 201, 0);
    run_seq(2, 0, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule